// File: doc/BRIEF.md
# Ready-Tracked Scratchpad with Per-Chunk Full/Empty Bits

This block wraps an accelerator's local scratchpad so that computation can start while an inbound DMA transfer is still running. The word array is split into fixed-size chunks. A separate bit vector holds one full/empty flag per chunk, selected by the upper bits of the word address. The DMA write port fills words in order. When it writes the final word of a chunk, that chunk's flag becomes full.

Each datapath lane has its own load port. A lane raises its request with an address and holds it. The flag and the data word are looked up in the same cycle. If the chunk is full, the load is accepted and the word appears on the lane's output in the next cycle. If the chunk is empty, only that lane sees a stall, and it keeps its request up until the chunk fills. A same-cycle bypass lets a stalled lane go on the very cycle in which the DMA writes the word that completes its chunk. A clear input empties every flag before a new transfer.

The chunk size is a parameter. One cache line is the usual setting. Setting it to half the array size splits the scratchpad into two halves that fill one after the other, which gives double-buffered use.

Top module: `fe_spad`

## Requirements
- R1: After reset every chunk flag is empty: a lane request then shows stall high, and every lane valid output is low.
- R2: The chunk index of an address is the address shifted right by log2(CHUNK_WORDS). A chunk's flag becomes full only through a DMA write whose word offset within the chunk equals CHUNK_WORDS-1. Writes to other offsets leave a requesting lane stalled.
- R3: A request to a full chunk shows stall low in that cycle. The lane's valid goes high in the next cycle, for exactly one cycle per accepted load, with the stored word on its data output.
- R4: A request to an empty chunk shows stall high and produces no valid in the next cycle. This continues for as long as the chunk stays empty.
- R5: When the DMA writes the final word of a chunk in the same cycle as a lane request to that chunk, stall is low in that cycle. The data follows in the next cycle, including when the requested word is the one being written.
- R6: Lanes are independent: a stalled lane does not hold back a lane whose chunk is full.
- R7: Clear empties every flag at the next edge and wins over a flag set in the same cycle. Flags never drop in any other way, and clear leaves the word contents unchanged.
- R8: With CHUNK_WORDS equal to half the depth, the two halves are tracked separately: the low half becomes readable after its final word is written, while the high half stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty all chunk flags at the next edge |
| dma_we_i | input | 1 | DMA write strobe |
| dma_addr_i | input | ADDR_W | DMA word address |
| dma_wdata_i | input | DATA_W | DMA write data |
| lane_req_i | input | LANES | Per-lane load request, held until accepted |
| lane_addr_i | input | LANES*ADDR_W | Per-lane word address, lane l at bits l*ADDR_W |
| lane_stall_o | output | LANES | Lane request waits on an empty chunk |
| lane_valid_o | output | LANES | Load data valid, one cycle per accepted load |
| lane_rdata_o | output | LANES*DATA_W | Per-lane load data, lane l at bits l*DATA_W |

## Verification
A flag wrongly set shows up in the same cycle as a low stall on a lane whose chunk has not been completed, and one cycle later as a valid carrying a word the DMA has not yet written. A flag that is lost or never set shows as a stall that stays high after the final word of the chunk has been written. A broken bypass shows as one extra stall cycle on exactly the cycle that completes the chunk. Stale data from a missing write-forward shows on the data output one cycle after that bypass.

// File: rtl/fe_spad_pkg.sv
package fe_spad_pkg;
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/fe_spad_fill_track.sv
module fe_spad_fill_track #(
   parameter int unsigned NUM_CHUNKS = 8,
   parameter int unsigned IDX_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  set_i,
   input  logic [IDX_W-1:0]      set_idx_i,
   output logic [NUM_CHUNKS-1:0] full_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_o <= '0;
      end else if (clear_i) begin
         full_o <= '0;
      end else if (set_i) begin
         full_o[set_idx_i] <= 1'b1;
      end
   end
endmodule

// File: rtl/fe_spad_store.sv
module fe_spad_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 2
) (
   input  logic                    clk,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       waddr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic [LANES*ADDR_W-1:0] raddr_i,
   output logic [LANES*DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         words[waddr_i] <= wdata_i;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      logic [ADDR_W-1:0] ra;
      assign ra = raddr_i[l*ADDR_W +: ADDR_W];
      always_comb begin
         if (we_i && (waddr_i == ra)) begin
            rdata_o[l*DATA_W +: DATA_W] = wdata_i;
         end else begin
            rdata_o[l*DATA_W +: DATA_W] = words[ra];
         end
      end
   end
endmodule

// File: rtl/fe_spad_lane_gate.sv
module fe_spad_lane_gate #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_CHUNKS = 8,
   parameter int unsigned IDX_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [NUM_CHUNKS-1:0] full_i,
   input  logic                  set_i,
   input  logic [IDX_W-1:0]      set_idx_i,
   input  logic [DATA_W-1:0]     word_i,
   output logic                  stall_o,
   output logic                  valid_o,
   output logic [DATA_W-1:0]     rdata_o
);
   logic ready;
   logic accept;

   assign ready   = full_i[idx_i] | (set_i & (set_idx_i == idx_i));
   assign accept  = req_i & ready;
   assign stall_o = req_i & ~ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         rdata_o <= '0;
      end else begin
         valid_o <= accept;
         if (accept) begin
            rdata_o <= word_i;
         end
      end
   end
endmodule

// File: rtl/fe_spad.sv
module fe_spad
   import fe_spad_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CHUNK_WORDS = 8,
   parameter int unsigned LANES       = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear_i,
   input  logic                    dma_we_i,
   input  logic [ADDR_W-1:0]       dma_addr_i,
   input  logic [DATA_W-1:0]       dma_wdata_i,
   input  logic [LANES-1:0]        lane_req_i,
   input  logic [LANES*ADDR_W-1:0] lane_addr_i,
   output logic [LANES-1:0]        lane_stall_o,
   output logic [LANES-1:0]        lane_valid_o,
   output logic [LANES*DATA_W-1:0] lane_rdata_o
);
   localparam int unsigned DEPTH      = 1 << ADDR_W;
   localparam int unsigned CHUNK_LOG2 = $clog2(CHUNK_WORDS);
   localparam int unsigned NUM_CHUNKS = DEPTH / CHUNK_WORDS;
   localparam int unsigned IDX_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

   if (!is_pow2(CHUNK_WORDS)) begin : g_chk_pow2
      $error("CHUNK_WORDS must be a power of two");
   end
   if (CHUNK_WORDS > DEPTH) begin : g_chk_range
      $error("CHUNK_WORDS must not exceed the array depth");
   end
   if (LANES < 1 || DATA_W < 1 || ADDR_W < 1) begin : g_chk_sizes
      $error("LANES, DATA_W and ADDR_W must be at least 1");
   end

   logic                  dma_last;
   logic [IDX_W-1:0]      dma_idx;
   logic                  set_go;
   logic [NUM_CHUNKS-1:0] fill_bits;
   logic [LANES*DATA_W-1:0] store_rdata;

   // chunk geometry variant chosen by the parameters
   if (CHUNK_LOG2 == 0) begin : g_word_grain
      assign dma_last = 1'b1;
      assign dma_idx  = dma_addr_i;
   end else if (CHUNK_LOG2 == ADDR_W) begin : g_one_chunk
      assign dma_last = &dma_addr_i;
      assign dma_idx  = '0;
   end else begin : g_sliced
      assign dma_last = &dma_addr_i[CHUNK_LOG2-1:0];
      assign dma_idx  = dma_addr_i[ADDR_W-1:CHUNK_LOG2];
   end

   assign set_go = dma_we_i & dma_last & ~clear_i;

   fe_spad_fill_track #(
      .NUM_CHUNKS(NUM_CHUNKS),
      .IDX_W     (IDX_W)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear_i),
      .set_i    (set_go),
      .set_idx_i(dma_idx),
      .full_o   (fill_bits)
   );

   fe_spad_store #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .LANES (LANES)
   ) u_store (
      .clk    (clk),
      .we_i   (dma_we_i),
      .waddr_i(dma_addr_i),
      .wdata_i(dma_wdata_i),
      .raddr_i(lane_addr_i),
      .rdata_o(store_rdata)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [ADDR_W-1:0] la;
      logic [IDX_W-1:0]  lidx;
      assign la = lane_addr_i[l*ADDR_W +: ADDR_W];
      if (CHUNK_LOG2 == 0) begin : g_idx_word
         assign lidx = la;
      end else if (CHUNK_LOG2 == ADDR_W) begin : g_idx_one
         assign lidx = '0;
      end else begin : g_idx_slice
         assign lidx = la[ADDR_W-1:CHUNK_LOG2];
      end

      fe_spad_lane_gate #(
         .DATA_W    (DATA_W),
         .NUM_CHUNKS(NUM_CHUNKS),
         .IDX_W     (IDX_W)
      ) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_i    (lane_req_i[l]),
         .idx_i    (lidx),
         .full_i   (fill_bits),
         .set_i    (set_go),
         .set_idx_i(dma_idx),
         .word_i   (store_rdata[l*DATA_W +: DATA_W]),
         .stall_o  (lane_stall_o[l]),
         .valid_o  (lane_valid_o[l]),
         .rdata_o  (lane_rdata_o[l*DATA_W +: DATA_W])
      );
   end
endmodule

// File: rtl/fe_spad_chk.sv
module fe_spad_chk #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CHUNK_WORDS = 8,
   parameter int unsigned LANES       = 2,
   parameter int unsigned NUM_CHUNKS  = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  clear_i,
   input logic                  dma_we_i,
   input logic [ADDR_W-1:0]     dma_addr_i,
   input logic [LANES-1:0]      lane_req_i,
   input logic [LANES-1:0]      lane_stall_o,
   input logic [LANES-1:0]      lane_valid_o,
   input logic [NUM_CHUNKS-1:0] fill_bits
);
   logic last_word;
   assign last_word = dma_we_i &&
      ((int'(dma_addr_i) % int'(CHUNK_WORDS)) == int'(CHUNK_WORDS) - 1);

   AST_SET_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      !last_word |=> ($countones(fill_bits) <= $past($countones(fill_bits)))); // R2

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (fill_bits == '0)); // R7

   AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((fill_bits & $past(fill_bits)) == $past(fill_bits))); // R7

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_req_i[l] && !lane_stall_o[l]) |=> lane_valid_o[l]); // R3

      AST_NO_VALID_IF_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_req_i[l] && lane_stall_o[l]) |=> !lane_valid_o[l]); // R4

      AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         lane_stall_o[l] |-> lane_req_i[l]); // R4
   end
endmodule

bind fe_spad fe_spad_chk #(
   .ADDR_W     (ADDR_W),
   .CHUNK_WORDS(CHUNK_WORDS),
   .LANES      (LANES),
   .NUM_CHUNKS (NUM_CHUNKS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clear_i     (clear_i),
   .dma_we_i    (dma_we_i),
   .dma_addr_i  (dma_addr_i),
   .lane_req_i  (lane_req_i),
   .lane_stall_o(lane_stall_o),
   .lane_valid_o(lane_valid_o),
   .fill_bits   (fill_bits)
);

// File: tb/fe_spad_bench.sv
module fe_spad_bench;
   localparam int unsigned DW = 16;
   localparam int unsigned AW = 5;
   localparam int unsigned CW = 4;
   localparam int unsigned NL = 2;

   typedef struct packed {
      logic        we;
      logic [4:0]  da;
      logic        req;
      logic [4:0]  la;
      logic        xs;
      logic        xv;
      logic [15:0] xd;
      logic [3:0]  rq;
   } vec_t;

   // chunk size 4: chunk 0 = words 0..3, chunk 1 = words 4..7
   localparam vec_t TBL [10] = '{
      '{1'b0, 5'd0, 1'b1, 5'd2, 1'b1, 1'b0, 16'h0000, 4'd4}, // R4 empty
      '{1'b1, 5'd0, 1'b1, 5'd2, 1'b1, 1'b0, 16'h0000, 4'd2}, // R2 offset 0
      '{1'b1, 5'd1, 1'b1, 5'd2, 1'b1, 1'b0, 16'h0000, 4'd2}, // R2 offset 1
      '{1'b1, 5'd2, 1'b1, 5'd2, 1'b1, 1'b0, 16'h0000, 4'd2}, // R2 own word, not last
      '{1'b1, 5'd3, 1'b1, 5'd2, 1'b0, 1'b1, 16'hA002, 4'd5}, // R5 bypass
      '{1'b1, 5'd4, 1'b1, 5'd3, 1'b0, 1'b1, 16'hA003, 4'd3}, // R3 full chunk
      '{1'b1, 5'd5, 1'b1, 5'd7, 1'b1, 1'b0, 16'h0000, 4'd4}, // R4 chunk 1 open
      '{1'b1, 5'd6, 1'b0, 5'd0, 1'b0, 1'b0, 16'h0000, 4'd3}, // R3 no request
      '{1'b1, 5'd7, 1'b1, 5'd7, 1'b0, 1'b1, 16'hA007, 4'd5}, // R5 forwarded word
      '{1'b0, 5'd0, 1'b1, 5'd4, 1'b0, 1'b1, 16'hA004, 4'd3}  // R3 after fill
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            clear;
   logic            dwe;
   logic [AW-1:0]   daddr;
   logic [DW-1:0]   ddata;
   logic [NL-1:0]   req;
   logic [NL*AW-1:0] laddr;
   logic [NL-1:0]   stall;
   logic [NL-1:0]   valid;
   logic [NL*DW-1:0] rdata;

   logic            h_dwe;
   logic [AW-1:0]   h_daddr;
   logic [DW-1:0]   h_ddata;
   logic            h_req;
   logic [AW-1:0]   h_laddr;
   logic            h_stall;
   logic            h_valid;
   logic [DW-1:0]   h_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fe_spad #(.DATA_W(DW), .ADDR_W(AW), .CHUNK_WORDS(CW), .LANES(NL)) u_fe_spad (
      .clk(clk), .rst_n(rst_n), .clear_i(clear),
      .dma_we_i(dwe), .dma_addr_i(daddr), .dma_wdata_i(ddata),
      .lane_req_i(req), .lane_addr_i(laddr),
      .lane_stall_o(stall), .lane_valid_o(valid), .lane_rdata_o(rdata));

   fe_spad #(.DATA_W(DW), .ADDR_W(AW), .CHUNK_WORDS(16), .LANES(1)) u_fe_spad_half (
      .clk(clk), .rst_n(rst_n), .clear_i(1'b0),
      .dma_we_i(h_dwe), .dma_addr_i(h_daddr), .dma_wdata_i(h_ddata),
      .lane_req_i(h_req), .lane_addr_i(h_laddr),
      .lane_stall_o(h_stall), .lane_valid_o(h_valid), .lane_rdata_o(h_rdata));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic [AW-1:0] da, input logic [DW-1:0] dd,
                        input logic r0, input logic [AW-1:0] a0,
                        input logic r1, input logic [AW-1:0] a1);
      dwe   = we;
      daddr = da;
      ddata = dd;
      req   = {r1, r0};
      laddr = {a1, a0};
   endtask

   task automatic next_cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      clear = 1'b0;
      drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
      h_dwe = 1'b0; h_daddr = '0; h_ddata = '0; h_req = 1'b0; h_laddr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset leaves every chunk empty and no valid
      drive(1'b0, '0, '0, 1'b1, 5'd0, 1'b1, 5'd20);
      #1;
      check("R1 stall lane0 after reset", 32'(stall[0]), 32'd1);
      check("R1 stall lane1 after reset", 32'(stall[1]), 32'd1);
      check("R1 valid after reset", 32'(valid), 32'd0);
      next_cycle();
      check("R1 no valid from empty chunk", 32'(valid), 32'd0);

      // table walk on lane 0
      for (int i = 0; i < 10; i++) begin
         drive(TBL[i].we, TBL[i].da, 16'hA000 + 16'(TBL[i].da), TBL[i].req, TBL[i].la, 1'b0, '0);
         #1;
         check($sformatf("R%0d row %0d stall", TBL[i].rq, i), 32'(stall[0]), 32'(TBL[i].xs));
         next_cycle();
         check($sformatf("R%0d row %0d valid", TBL[i].rq, i), 32'(valid[0]), 32'(TBL[i].xv));
         if (TBL[i].xv) begin
            check($sformatf("R%0d row %0d data", TBL[i].rq, i), 32'(rdata[DW-1:0]), 32'(TBL[i].xd));
         end
      end

      // R3: single valid per accepted load
      drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
      next_cycle();
      check("R3 valid drops after one load", 32'(valid[0]), 32'd0);
      check("R3 data held", 32'(rdata[DW-1:0]), 32'hA004);

      // R6: lane 1 stalls on chunk 2 while lane 0 proceeds
      drive(1'b0, '0, '0, 1'b1, 5'd1, 1'b1, 5'd9);
      #1;
      check("R6 lane1 stalled", 32'(stall[1]), 32'd1);
      check("R6 lane0 not held back", 32'(stall[0]), 32'd0);
      next_cycle();
      check("R6 lane0 valid", 32'(valid[0]), 32'd1);
      check("R6 lane0 data", 32'(rdata[DW-1:0]), 32'hA001);
      check("R6 lane1 no valid", 32'(valid[1]), 32'd0);
      for (int a = 8; a < 11; a++) begin
         drive(1'b1, 5'(a), 16'hB000 + 16'(a), 1'b0, '0, 1'b1, 5'd9);
         #1;
         check("R4 lane1 stays stalled", 32'(stall[1]), 32'd1);
         next_cycle();
         check("R4 lane1 still no valid", 32'(valid[1]), 32'd0);
      end
      drive(1'b1, 5'd11, 16'hB00B, 1'b0, '0, 1'b1, 5'd9);
      #1;
      check("R5 lane1 released on last word", 32'(stall[1]), 32'd0);
      next_cycle();
      check("R5 lane1 valid", 32'(valid[1]), 32'd1);
      check("R5 lane1 data", 32'(rdata[2*DW-1:DW]), 32'hB009);

      // R7: clear wins over same-cycle completion, and empties full chunks
      for (int a = 12; a < 15; a++) begin
         drive(1'b1, 5'(a), 16'hB000 + 16'(a), 1'b0, '0, 1'b0, '0);
         next_cycle();
      end
      clear = 1'b1;
      drive(1'b1, 5'd15, 16'hB00F, 1'b0, '0, 1'b0, '0);
      next_cycle();
      clear = 1'b0;
      drive(1'b0, '0, '0, 1'b1, 5'd12, 1'b1, 5'd0);
      #1;
      check("R7 clear beats same-cycle set", 32'(stall[0]), 32'd1);
      check("R7 clear empties chunk 0", 32'(stall[1]), 32'd1);
      next_cycle();
      check("R7 no valid after clear", 32'(valid), 32'd0);
      drive(1'b1, 5'd3, 16'hC003, 1'b1, 5'd1, 1'b0, '0);
      #1;
      check("R7 chunk 0 refilled", 32'(stall[0]), 32'd0);
      next_cycle();
      check("R7 data survives clear", 32'(rdata[DW-1:0]), 32'hA001);
      drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

      // R8: half-array granularity on the second instance
      for (int a = 0; a < 15; a++) begin
         h_dwe = 1'b1; h_daddr = 5'(a); h_ddata = 16'hD000 + 16'(a);
         h_req = 1'b1; h_laddr = 5'd0;
         #1;
         if (a == 0 || a == 14) check("R8 low half stalled until full", 32'(h_stall), 32'd1);
         next_cycle();
      end
      h_daddr = 5'd15; h_ddata = 16'hD00F; h_laddr = 5'd3;
      #1;
      check("R8 low half released", 32'(h_stall), 32'd0);
      next_cycle();
      check("R8 low half data", 32'(h_rdata), 32'hD003);
      h_daddr = 5'd16; h_ddata = 16'hD010; h_laddr = 5'd20;
      #1;
      check("R8 high half still stalled", 32'(h_stall), 32'd1);
      next_cycle();
      h_dwe = 1'b0; h_laddr = 5'd5;
      #1;
      check("R8 low half stays readable", 32'(h_stall), 32'd0);
      next_cycle();
      check("R8 low half data second read", 32'(h_rdata), 32'hD005);
      h_req = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule